// File: doc/BRIEF.md
# Digital Floppy Read-Data Separator

This block turns the raw read pulse train of a floppy drive into a recovered data-window clock and a clean stream of separated data pulses. It works for both single-density (FM) and double-density (MFM) recordings. A mode-selected prescaler divides the reference clock into an internal clock. Everything else runs on that internal clock.

The recovered clock comes from a digital phase-locked loop. Each half-cycle is nominally eight internal clocks long. The loop locks to the falling (leading) edge of each raw pulse. A short-term correction stretches or trims the current half-cycle by one count, and the length of every half-cycle stays between 6 and 11 counts. A long-term correction moves the nominal half-cycle length by one count after a run of errors with the same sign, which follows slow speed drift of the drive. Pulses that arrive while the recovered clock is high are data bits. Each one produces a separated data pulse two internal clocks wide. The active level of that output follows the controller-type select.

Top module: `floppy_data_sep`

## Requirements
- R1: The internal clock ratio is set by the mode word {ctl_type, dens_sel, mini_sel}: 000→2, 001→4, 010→4, 011→8, 100→4, 101→8, 110→2, 111→4 reference clocks per internal clock.
- R2: With no read pulses, sep_clk toggles every 8 internal clocks, so each half lasts 8×ratio reference clocks. sep_clk changes only on an internal clock.
- R3: Only the falling edge of rd_data_n is used, once per pulse. A low level held over many internal clocks produces a single event, and a rising edge produces none.
- R4: An event handled while the count into the current half is below 4 shortens that half by one internal clock. An event handled above 4 lengthens it by one. This applies unless the half ends on that same internal clock. An event at count 4 makes no change.
- R5: After correction, every half-cycle of sep_clk lasts at least 6 and at most 11 internal clocks. Further corrections in the same direction saturate at these limits.
- R6: Four consecutive events of the same error sign move the nominal half length by one in that direction, within 7 to 9. Later halves start from the new nominal value.
- R7: An event handled while sep_clk is high (data window) yields exactly one separated data pulse. An event while sep_clk is low (clock window) yields none.
- R8: A separated data pulse lasts exactly 2 internal clocks. An event that arrives while a pulse is active is ignored for data output.
- R9: sep_data is active-low (idle high) when ctl_type is 0, and active-high (idle low) when ctl_type is 1.
- R10: During and just after reset, sep_clk is low, no data pulse is active, and the nominal half length is 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_type | input | 1 | Controller-type select; also picks sep_data polarity |
| dens_sel | input | 1 | Density select |
| mini_sel | input | 1 | Drive-size select |
| rd_data_n | input | 1 | Raw read pulses from the drive, low-going, asynchronous |
| sep_clk | output | 1 | Recovered data-window clock |
| sep_data | output | 1 | Separated data pulses |

## Verification
The bench places read pulses at known offsets inside a half-cycle. It injects one pulse early and one late, which catches a loop that corrects in the wrong direction: that loop would give halves of 18 and 14 reference clocks instead of 14 and 18. Bursts of three early and five late pulses drive the half-cycle into its 6 and 11 limits. These bursts show whether saturation is missing, and whether the long-term nominal shift comes too early, too late or not at all. A design that failed here would give halves longer or shorter than 48, 88 and 72. The bench also sends pulses in the clock window, a held-low pulse, and a pulse during an active data pulse. These would expose a design that emits data outside the data window, counts a level instead of an edge, or retriggers its pulse. Every prescaler mode and both output polarities are measured as well.

// File: rtl/fds_pkg.sv
package fds_pkg;

    localparam int unsigned DIV_MAX = 8;
    localparam int unsigned DIV_W   = $clog2(DIV_MAX + 1);

    typedef struct packed {
        logic ctl;
        logic dens;
        logic mini;
    } fds_mode_t;

    typedef enum logic [1:0] {
        PH_NONE  = 2'd0,
        PH_EARLY = 2'd1,
        PH_LATE  = 2'd2
    } fds_phase_e;

    // Reference clocks per internal clock for each mode word (R1)
    function automatic logic [DIV_W-1:0] fds_ratio(input fds_mode_t m);
        case ({m.ctl, m.dens, m.mini})
            3'b000:  return DIV_W'(2);
            3'b001:  return DIV_W'(4);
            3'b010:  return DIV_W'(4);
            3'b011:  return DIV_W'(8);
            3'b100:  return DIV_W'(4);
            3'b101:  return DIV_W'(8);
            3'b110:  return DIV_W'(2);
            default: return DIV_W'(4);
        endcase
    endfunction

endpackage

// File: rtl/fds_prescaler.sv
module fds_prescaler
    import fds_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] ratio,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    // ">=" keeps the count in range when the ratio shrinks mid-count
    assign tick = (cnt >= ratio - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + DIV_W'(1);
    end
endmodule

// File: rtl/fds_edge_sync.sv
module fds_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_n,
    input  logic tick,
    output logic evt
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;
    logic              pend_q;
    logic              fall;

    assign fall = last_q & ~sync_q[STAGES-1];
    assign evt  = tick & (pend_q | fall);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            last_q <= 1'b1;
            pend_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], raw_n};
            last_q <= sync_q[STAGES-1];
            // hold a detected edge until the next internal clock
            pend_q <= tick ? 1'b0 : (pend_q | fall);
        end
    end
endmodule

// File: rtl/fds_dpll.sv
module fds_dpll
    import fds_pkg::*;
#(
    parameter int unsigned HALF_NOM = 8,
    parameter int unsigned HALF_MIN = 6,
    parameter int unsigned HALF_MAX = 11,
    parameter int unsigned NOM_LO   = 7,
    parameter int unsigned NOM_HI   = 9,
    parameter int unsigned LT_RUN   = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic evt,
    output logic sep_clk,
    output logic win_evt
);
    localparam int unsigned LW = $clog2(HALF_MAX + 1);
    localparam int unsigned RW = $clog2(LT_RUN + 1);
    localparam logic [LW-1:0] MID = LW'(HALF_NOM / 2);

    logic [LW-1:0] hc_q, len_q, nom_q;
    logic [LW-1:0] len_adj, nom_nx;
    logic [RW-1:0] run_q, run_nx;
    fds_phase_e    sign_q, sign_nx, ph;
    logic          clk_q, half_end;

    always_comb begin
        ph = PH_NONE;
        if (evt) begin
            if (hc_q < MID)      ph = PH_EARLY;
            else if (hc_q > MID) ph = PH_LATE;
        end
    end

    assign half_end = (hc_q >= len_q - LW'(1));

    // long-term drift tracking
    always_comb begin
        nom_nx  = nom_q;
        sign_nx = sign_q;
        run_nx  = run_q;
        if (ph != PH_NONE) begin
            if (ph == sign_q && run_q == RW'(LT_RUN - 1)) begin
                run_nx = '0;
                if (ph == PH_EARLY && nom_q > LW'(NOM_LO)) nom_nx = nom_q - LW'(1);
                if (ph == PH_LATE  && nom_q < LW'(NOM_HI)) nom_nx = nom_q + LW'(1);
            end else if (ph == sign_q) begin
                run_nx = run_q + RW'(1);
            end else begin
                sign_nx = ph;
                run_nx  = RW'(1);
            end
        end
    end

    // short-term correction, saturating
    always_comb begin
        len_adj = len_q;
        if (ph == PH_EARLY && len_q > LW'(HALF_MIN)) len_adj = len_q - LW'(1);
        if (ph == PH_LATE  && len_q < LW'(HALF_MAX)) len_adj = len_q + LW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hc_q   <= '0;
            len_q  <= LW'(HALF_NOM);
            nom_q  <= LW'(HALF_NOM);
            sign_q <= PH_NONE;
            run_q  <= '0;
            clk_q  <= 1'b0;
        end else if (tick) begin
            nom_q  <= nom_nx;
            sign_q <= sign_nx;
            run_q  <= run_nx;
            if (half_end) begin
                clk_q <= ~clk_q;
                hc_q  <= '0;
                len_q <= nom_nx;
            end else begin
                hc_q  <= hc_q + LW'(1);
                len_q <= len_adj;
            end
        end
    end

    assign sep_clk = clk_q;
    assign win_evt = evt & clk_q;
endmodule

// File: rtl/fds_pulse.sv
module fds_pulse #(
    parameter int unsigned TICKS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic start,
    output logic active
);
    localparam int unsigned W = $clog2(TICKS + 1);

    logic [W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (tick) begin
            if (left_q == '0 && start) left_q <= W'(TICKS);
            else if (left_q != '0)     left_q <= left_q - W'(1);
        end
    end

    assign active = (left_q != '0);
endmodule

// File: rtl/floppy_data_sep.sv
module floppy_data_sep
    import fds_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned HALF_NOM    = 8,
    parameter int unsigned HALF_MIN    = 6,
    parameter int unsigned HALF_MAX    = 11,
    parameter int unsigned NOM_LO      = 7,
    parameter int unsigned NOM_HI      = 9,
    parameter int unsigned LT_RUN      = 4,
    parameter int unsigned PULSE_TICKS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ctl_type,
    input  logic dens_sel,
    input  logic mini_sel,
    input  logic rd_data_n,
    output logic sep_clk,
    output logic sep_data
);
    fds_mode_t        mode;
    logic [DIV_W-1:0] ratio;
    logic             tick, evt, win_evt, pulse_act;

    assign mode  = '{ctl: ctl_type, dens: dens_sel, mini: mini_sel};
    assign ratio = fds_ratio(mode);

    fds_prescaler u_pre (
        .clk  (clk),
        .rst  (rst),
        .ratio(ratio),
        .tick (tick)
    );

    fds_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .raw_n(rd_data_n),
        .tick (tick),
        .evt  (evt)
    );

    fds_dpll #(
        .HALF_NOM(HALF_NOM), .HALF_MIN(HALF_MIN), .HALF_MAX(HALF_MAX),
        .NOM_LO(NOM_LO), .NOM_HI(NOM_HI), .LT_RUN(LT_RUN)
    ) u_pll (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .evt    (evt),
        .sep_clk(sep_clk),
        .win_evt(win_evt)
    );

    fds_pulse #(.TICKS(PULSE_TICKS)) u_pulse (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .start (win_evt),
        .active(pulse_act)
    );

    assign sep_data = ctl_type ? pulse_act : ~pulse_act;
endmodule

// File: rtl/fds_checker.sv
module fds_checker
    import fds_pkg::*;
#(
    parameter int unsigned HALF_MIN    = 6,
    parameter int unsigned HALF_MAX    = 11,
    parameter int unsigned PULSE_TICKS = 2
) (
    input logic clk,
    input logic rst,
    input logic tick,
    input logic sep_clk,
    input logic pulse_act
);
    logic       prev_clk;
    logic [7:0] half_cnt, pls_cnt, gap_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_clk <= 1'b0;
            half_cnt <= '0;
            pls_cnt  <= '0;
            gap_cnt  <= '0;
        end else begin
            prev_clk <= sep_clk;
            if (sep_clk != prev_clk) half_cnt <= tick ? 8'd1 : 8'd0;
            else if (tick)           half_cnt <= half_cnt + 8'd1;
            if (!pulse_act)          pls_cnt <= '0;
            else if (tick)           pls_cnt <= pls_cnt + 8'd1;
            gap_cnt <= tick ? 8'd0 : gap_cnt + 8'd1;
        end
    end

    assert_tick_gap_R1: assert property (@(posedge clk) disable iff (rst)
        gap_cnt < 8'(DIV_MAX));

    assert_clk_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
        (sep_clk != prev_clk) |-> $past(tick));

    assert_half_bounds_R5: assert property (@(posedge clk) disable iff (rst)
        (sep_clk != prev_clk) |-> (half_cnt >= 8'(HALF_MIN) && half_cnt <= 8'(HALF_MAX)));

    assert_pulse_window_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_act) |-> $past(sep_clk));

    assert_pulse_len_R8: assert property (@(posedge clk) disable iff (rst)
        pulse_act |-> (pls_cnt < 8'(PULSE_TICKS)));
endmodule

bind floppy_data_sep fds_checker #(
    .HALF_MIN(HALF_MIN), .HALF_MAX(HALF_MAX), .PULSE_TICKS(PULSE_TICKS)
) u_fds_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .sep_clk  (sep_clk),
    .pulse_act(pulse_act)
);

// File: tb/tb_floppy_data_sep.sv
module tb_floppy_data_sep;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ctl_type = 1'b0, dens_sel = 1'b0, mini_sel = 1'b0;
    logic rd_data_n = 1'b1;
    logic sep_clk, sep_data;

    always #10 clk = ~clk;

    floppy_data_sep dut (
        .clk(clk), .rst(rst), .ctl_type(ctl_type), .dens_sel(dens_sel),
        .mini_sel(mini_sel), .rd_data_n(rd_data_n),
        .sep_clk(sep_clk), .sep_data(sep_data)
    );

    int n_chk = 0;
    int n_fail = 0;
    int exp_q[$];
    string req_q[$];
    int ratio_tab[8] = '{2, 4, 4, 8, 4, 8, 2, 4};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor: half-cycle lengths in reference clocks, compared against the queue
    logic mon_prev = 1'b0;
    int   mon_run = 0;
    always @(negedge clk) begin
        if (rst) begin
            mon_prev = sep_clk;
            mon_run  = 0;
        end else begin
            mon_run++;
            if (sep_clk !== mon_prev) begin
                if (exp_q.size() > 0) begin
                    int e;
                    string r;
                    e = exp_q.pop_front();
                    r = req_q.pop_front();
                    chk(mon_run == e, r, mon_run, e);
                end
                mon_run  = 0;
                mon_prev = sep_clk;
            end
        end
    end

    // monitor: separated data pulses
    int dp_cnt = 0, dp_w = 0, dp_run = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (sep_data === ctl_type) begin
                if (dp_run == 0) dp_cnt++;
                dp_run++;
            end else begin
                if (dp_run != 0) dp_w = dp_run;
                dp_run = 0;
            end
        end
    end

    task automatic push_exp(input int e, input string r);
        #1;
        exp_q.push_back(e);
        req_q.push_back(r);
    endtask

    task automatic wait_any;
        logic s;
        s = sep_clk;
        do @(negedge clk); while (sep_clk === s);
    endtask

    task automatic wait_to(input logic v);
        while (sep_clk === v) @(negedge clk);
        while (sep_clk !== v) @(negedge clk);
    endtask

    task automatic edge_at(input int d, input int low_len);
        repeat (d) @(negedge clk);
        rd_data_n = 1'b0;
        repeat (low_len) @(negedge clk);
        rd_data_n = 1'b1;
    endtask

    task automatic do_reset(input logic [2:0] m);
        @(negedge clk);
        {ctl_type, dens_sel, mini_sel} = m;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        int c0;
        repeat (3) @(negedge clk);
        chk(sep_clk === 1'b0, "R10 sep_clk in reset", int'(sep_clk), 0);
        chk(sep_data === 1'b1, "R10 R9 sep_data idle in reset", int'(sep_data), 1);
        rst = 1'b0;

        // R1 / R2: free-running half length in every mode
        for (int m = 0; m < 8; m++) begin
            @(negedge clk);
            {ctl_type, dens_sel, mini_sel} = 3'(m);
            wait_any();
            wait_any();
            push_exp(8 * ratio_tab[m], $sformatf("R1 R2 mode %0d half", m));
            wait_any();
        end

        // R4: single early and late corrections, ratio 2
        do_reset(3'b000);
        wait_any();
        push_exp(14, "R4 early shortens");
        edge_at(1, 3);
        wait_any();
        push_exp(18, "R4 late lengthens");
        edge_at(8, 3);
        wait_any();
        push_exp(16, "R2 nominal restored");
        wait_any();

        // R5 lower limit, ratio 8
        do_reset(3'b011);
        wait_any();
        push_exp(48, "R5 min saturation");
        edge_at(1, 3);
        edge_at(5, 3);
        edge_at(5, 3);
        wait_any();
        push_exp(64, "R6 no shift before run");
        wait_any();

        // R5 upper limit and R6 long-term shift
        do_reset(3'b011);
        wait_any();
        push_exp(88, "R5 max saturation");
        edge_at(41, 3);
        edge_at(5, 3);
        edge_at(5, 3);
        edge_at(5, 3);
        edge_at(5, 3);
        wait_any();
        push_exp(72, "R6 nominal shifted");
        wait_any();
        push_exp(72, "R6 nominal held");
        wait_any();

        // R7 / R8 / R3 data pulses, ratio 2, active-low
        do_reset(3'b000);
        wait_to(1'b1);
        c0 = dp_cnt;
        edge_at(1, 3);
        repeat (12) @(negedge clk);
        chk(dp_cnt == c0 + 1, "R7 data window pulse", dp_cnt - c0, 1);
        chk(dp_w == 4, "R8 pulse width ratio 2", dp_w, 4);

        wait_to(1'b0);
        c0 = dp_cnt;
        edge_at(1, 3);
        repeat (12) @(negedge clk);
        chk(dp_cnt == c0, "R7 clock window none", dp_cnt - c0, 0);

        wait_to(1'b1);
        c0 = dp_cnt;
        edge_at(1, 40);
        repeat (12) @(negedge clk);
        chk(dp_cnt == c0 + 1, "R3 held low single event", dp_cnt - c0, 1);

        // R8 no retrigger, ratio 8
        do_reset(3'b011);
        wait_to(1'b1);
        c0 = dp_cnt;
        edge_at(1, 3);
        edge_at(5, 3);
        repeat (30) @(negedge clk);
        chk(dp_cnt == c0 + 1, "R8 retrigger ignored", dp_cnt - c0, 1);
        chk(dp_w == 16, "R8 pulse width ratio 8", dp_w, 16);

        // R9 active-high polarity, ratio 4
        do_reset(3'b100);
        chk(sep_data === 1'b0, "R9 idle low", int'(sep_data), 0);
        wait_to(1'b1);
        c0 = dp_cnt;
        edge_at(1, 3);
        repeat (20) @(negedge clk);
        chk(dp_cnt == c0 + 1, "R9 active-high pulse", dp_cnt - c0, 1);
        chk(dp_w == 8, "R9 R8 pulse width ratio 4", dp_w, 8);

        chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule